// File: doc/BRIEF.md
# I2C Target Front End with High-Speed Mode Entry

This block is the bus-facing half of a two-wire (I2C) target. A fast system clock samples the SCL and SDA lines through synchronizers. The block finds START, repeated START and STOP conditions, compares the address byte with a fixed 7-bit target address, and moves data bytes. If the R/W bit is 0 it receives bytes from the controller. If the R/W bit is 1 it returns bytes to the controller. The block drives SDA only through an open-drain enable: a 1 on `sda_oe` pulls the line low.

The block also watches for the high-speed master code. This is any byte of the form `0000_1xxx` that comes straight after a START, whatever target it is meant for. The block does not acknowledge that byte. At the end of its ninth clock the block sets a mode flag, `hs_mode`. The flag stays set across repeated STARTs and clears on any STOP. The surrounding logic uses the flag to pick its bus timing.

Received bytes appear on `rx_byte` with a one-cycle `rx_valid` strobe. The byte to return on a read is taken from `tx_byte` at the moment the block starts driving it.

Top module: `i2c_hs_target`

## Requirements
- R1: While `rst` is high and just after it falls, `sda_oe`, `rx_valid` and `hs_mode` are all 0.
- R2: An address byte whose upper seven bits equal 7'b0110110 is acknowledged. `sda_oe` is 1 from the SCL fall after the eighth bit to the SCL fall after the ninth clock, so SDA reads low while SCL is high on the ninth clock.
- R3: After an address byte that neither matches nor is a master code, the block keeps `sda_oe` at 0 and gives no `rx_valid` until the next START.
- R4: After an address byte with bit 0 = 0, each further byte is taken MSB first and placed on `rx_byte` with `rx_valid` high for exactly one cycle. The byte is then acknowledged on its ninth clock.
- R5: After an address byte with bit 0 = 1, the block samples `tx_byte` and drives it MSB first, with `sda_oe` = NOT bit. `sda_oe` only changes while the synchronized SCL is low.
- R6: On a read, a controller ACK (SDA low on the ninth clock) makes the block sample `tx_byte` again and send another byte. A NACK makes it release SDA and stay released.
- R7: A first byte after START whose upper five bits are 5'b00001 is not acknowledged. `hs_mode` becomes 1 after the SCL fall that ends its ninth clock.
- R8: `hs_mode` stays 1 across repeated STARTs, and the target still acknowledges its address and transfers data while in high-speed mode.
- R9: A STOP (SDA rising while SCL is high) clears `hs_mode` to 0. Nothing else clears it.
- R10: A START (SDA falling while SCL is high) seen at any point, including in the middle of a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| tx_byte | input | 8 | Byte returned to the controller on reads |
| rx_byte | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |
| hs_mode | output | 1 | 1 in high-speed mode, 0 in fast/standard mode |

## Verification
The embedded assertions check every cycle that:
- `sda_oe` never changes while the synchronized SCL is high;
- `rx_valid` never lasts two cycles;
- an ignored transfer never drives SDA;
- `hs_mode` only rises after a master code is completed and only falls after a STOP.

Only the bench's bit-banged scenarios can show the behaviours that depend on whole transfers:
- which address bytes are acknowledged (swept over all 128 addresses);
- that bytes arrive and leave intact (a write sweep of all 256 values and a multi-byte read);
- that `hs_mode` persists through repeated STARTs;
- recovery from a START in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef struct packed {
        logic scl;       // synchronized SCL level
        logic sda;       // synchronized SDA level
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_MCODE,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } eng_state_t;

    localparam eng_state_t ST_IGN = ST_IDLE;

    function automatic logic is_master_code(input logic [7:0] b);
        return b[7:3] == 5'b00001;
    endfunction

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
        return b[7:1] == own;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t ev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    logic scl_s, scl_d, sda_s, sda_d;
    assign scl_s = scl_p[STAGES-1];
    assign scl_d = scl_p[STAGES];
    assign sda_s = sda_p[STAGES-1];
    assign sda_d = sda_p[STAGES];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'b0110110,
    parameter int         DW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      ev,
    input  logic [DW-1:0] tx_byte,
    output logic          sda_oe,
    output logic [DW-1:0] rx_byte,
    output logic          rx_valid,
    output logic          mcode_done
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    eng_state_t    state;
    logic [DW-2:0] sh;
    logic [DW-1:0] tx_sh;
    logic [CW-1:0] cnt;
    logic          phase;
    logic          rw;
    logic          ctl_ack;
    logic [DW-1:0] byte_in;

    assign byte_in = {sh, ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sh         <= '0;
            tx_sh      <= '0;
            cnt        <= '0;
            phase      <= 1'b0;
            rw         <= 1'b0;
            ctl_ack    <= 1'b0;
            sda_oe     <= 1'b0;
            rx_byte    <= '0;
            rx_valid   <= 1'b0;
            mcode_done <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            mcode_done <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                phase  <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (ev.scl_rise) begin
                        sh  <= byte_in[DW-2:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            phase <= 1'b0;
                            if (is_master_code(byte_in)) begin
                                state <= ST_MCODE;
                            end else if (addr_hit(byte_in, OWN_ADDR)) begin
                                rw    <= byte_in[0];
                                state <= ST_AACK;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    ST_AACK, ST_WACK: if (ev.scl_fall) begin
                        if (!phase) begin
                            sda_oe <= 1'b1;
                            phase  <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            cnt   <= '0;
                            if (state == ST_AACK && rw) begin
                                tx_sh  <= tx_byte;
                                sda_oe <= ~tx_byte[DW-1];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_MCODE: if (ev.scl_fall) begin
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase      <= 1'b0;
                            mcode_done <= 1'b1;
                            state      <= ST_IGN;
                        end
                    end
                    ST_WR: if (ev.scl_rise) begin
                        sh  <= byte_in[DW-2:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            rx_byte  <= byte_in;
                            rx_valid <= 1'b1;
                            phase    <= 1'b0;
                            state    <= ST_WACK;
                        end
                    end
                    ST_RD: if (ev.scl_fall) begin
                        if (cnt == LAST) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~tx_sh[DW-2];
                            tx_sh  <= tx_sh << 1;
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) ctl_ack <= ~ev.sda;
                        if (ev.scl_fall) begin
                            if (ctl_ack) begin
                                tx_sh  <= tx_byte;
                                sda_oe <= ~tx_byte[DW-1];
                                cnt    <= '0;
                                state  <= ST_RD;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(ev.scl));

    // R4
    rx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R3
    ign_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGN) |-> !sda_oe);

endmodule

// File: rtl/i2c_tgt_mode.sv
module i2c_tgt_mode
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t ev,
    input  logic     mcode_done,
    output logic     hs_mode
);
    always_ff @(posedge clk) begin
        if (rst)             hs_mode <= 1'b0;
        else if (ev.stop)    hs_mode <= 1'b0;
        else if (mcode_done) hs_mode <= 1'b1;
    end

    // R9
    hs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_mode) |-> $past(ev.stop));

    // R7
    hs_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode) |-> $past(mcode_done));

endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'b0110110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       hs_mode
);
    bus_evt_t ev;
    logic     mcode_done;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_engine #(.OWN_ADDR(OWN_ADDR), .DW(8)) i_engine (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .tx_byte    (tx_byte),
        .sda_oe     (sda_oe),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .mcode_done (mcode_done)
    );

    i2c_tgt_mode i_mode (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .mcode_done (mcode_done),
        .hs_mode    (hs_mode)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !rx_valid && !hs_mode));

endmodule

// File: tb/test_i2c_hs_target.sv
module test_i2c_hs_target;
    localparam int T = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_ctl = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       hs_mode;

    int checks = 0;
    int failures = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_ctl & ~sda_oe;

    i2c_hs_target i_i2c_hs_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid), .hs_mode(hs_mode)
    );

    always @(negedge clk) if (rx_valid) begin
        rx_cnt++;
        rx_last = rx_byte;
    end

    task automatic wait_cy(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_ctl = 1; scl = 1; wait_cy(T);
        sda_ctl = 0; wait_cy(T);
        scl = 0; wait_cy(T);
    endtask

    task automatic bus_rstart();
        wait_cy(2); sda_ctl = 1; wait_cy(T);
        scl = 1; wait_cy(T);
        sda_ctl = 0; wait_cy(T);
        scl = 0; wait_cy(T);
    endtask

    task automatic bus_stop();
        wait_cy(2); sda_ctl = 0; wait_cy(T);
        scl = 1; wait_cy(T);
        sda_ctl = 1; wait_cy(T);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wait_cy(2); sda_ctl = b[i]; wait_cy(T);
            scl = 1; wait_cy(T);
            scl = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        wait_cy(2); sda_ctl = 1; wait_cy(T);
        scl = 1; wait_cy(T / 2);
        acked = (sda_line == 1'b0);
        wait_cy(T - T / 2);
        scl = 0; wait_cy(T);
    endtask

    task automatic recv_byte(input bit give_ack, input logic [7:0] next_tx,
                             output logic [7:0] v);
        sda_ctl = 1;
        for (int i = 7; i >= 0; i--) begin
            wait_cy(T); scl = 1; wait_cy(T / 2);
            v[i] = sda_line;
            wait_cy(T - T / 2); scl = 0;
        end
        tx_byte = next_tx;
        wait_cy(2); sda_ctl = give_ack ? 1'b0 : 1'b1; wait_cy(T);
        scl = 1; wait_cy(T);
        scl = 0; wait_cy(2); sda_ctl = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int rx_before;

        wait_cy(5);
        chk(sda_oe == 0 && rx_valid == 0 && hs_mode == 0, "R1", "reset outputs",
            {sda_oe, rx_valid, hs_mode}, 0);
        rst = 0;
        wait_cy(3);
        chk(sda_oe == 0 && rx_valid == 0 && hs_mode == 0, "R1", "after reset",
            {sda_oe, rx_valid, hs_mode}, 0);

        // R2 R3 R7 R9: every 7-bit address with R/W = 0
        for (int a = 0; a < 128; a++) begin
            bit exp_ack, exp_hs;
            exp_ack = (a == 7'h36);
            exp_hs  = (a >= 4 && a <= 7);
            bus_start();
            send_byte({a[6:0], 1'b0}, ack);
            chk(ack == exp_ack, exp_hs ? "R7" : (exp_ack ? "R2" : "R3"),
                $sformatf("ack addr %0h", a), ack, exp_ack);
            chk(hs_mode == exp_hs, "R7", $sformatf("hs after addr %0h", a), hs_mode, exp_hs);
            chk(sda_oe == 0, "R2", "released after ninth clock", sda_oe, 0);
            bus_stop();
            chk(hs_mode == 0, "R9", "stop clears hs", hs_mode, 0);
        end

        // R3: mismatched address, data ignored
        rx_before = rx_cnt;
        bus_start();
        send_byte(8'h6E, ack);
        send_byte(8'h00, ack);
        chk(!ack, "R3", "no ack on ignored data", ack, 0);
        send_byte(8'h5A, ack);
        chk(!ack && rx_cnt == rx_before, "R3", "no rx strobe when ignored", rx_cnt - rx_before, 0);
        bus_stop();

        // R4: write sweep of all byte values
        bus_start();
        send_byte(8'h6C, ack);
        chk(ack, "R2", "write address ack", ack, 1);
        for (int d = 0; d < 256; d++) begin
            rx_before = rx_cnt;
            send_byte(d[7:0], ack);
            chk(ack, "R4", "data ack", ack, 1);
            chk(rx_cnt == rx_before + 1 && rx_last == d[7:0], "R4",
                $sformatf("rx byte %0h", d), rx_last, d);
        end
        bus_stop();

        // R5 R6: multi-byte read, NACK on last
        tx_byte = 8'h00 * 8'd1 + 8'h13;
        bus_start();
        send_byte(8'h6D, ack);
        chk(ack, "R2", "read address ack", ack, 1);
        for (int k = 0; k < 32; k++) begin
            logic [7:0] expv, nxt;
            expv = 8'(k * 37 + 19);
            nxt  = 8'(k * 37 + 56);
            recv_byte(k != 31, nxt, v);
            chk(v == expv, k == 0 ? "R5" : "R6", $sformatf("read byte %0d", k), v, expv);
        end
        wait_cy(T);
        chk(sda_oe == 0, "R6", "released after nack", sda_oe, 0);
        scl = 1; wait_cy(T); scl = 0; wait_cy(T);
        chk(sda_oe == 0, "R6", "stays released after nack", sda_oe, 0);
        bus_stop();

        // R7 R8 R9: high-speed entry and persistence
        bus_start();
        send_byte(8'h0D, ack);
        chk(!ack, "R7", "master code nack", ack, 0);
        chk(hs_mode == 1, "R7", "hs set", hs_mode, 1);
        bus_rstart();
        chk(hs_mode == 1, "R8", "hs after repeated start", hs_mode, 1);
        send_byte(8'h6C, ack);
        chk(ack, "R8", "address ack in hs", ack, 1);
        send_byte(8'hA5, ack);
        chk(ack && rx_last == 8'hA5, "R8", "write in hs", rx_last, 8'hA5);
        tx_byte = 8'h3C;
        bus_rstart();
        send_byte(8'h6D, ack);
        recv_byte(1'b0, 8'h00, v);
        chk(v == 8'h3C, "R8", "read in hs", v, 8'h3C);
        chk(hs_mode == 1, "R8", "hs persists", hs_mode, 1);
        bus_stop();
        chk(hs_mode == 0, "R9", "stop ends hs", hs_mode, 0);

        // R10: START in the middle of a byte
        bus_start();
        send_bits(8'hF0, 4);
        bus_rstart();
        send_byte(8'h6C, ack);
        chk(ack, "R10", "ack after mid-byte restart", ack, 1);
        bus_stop();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule